// File: doc/BRIEF.md
# Serial ADC Output Frame Generator

This block models the serial data output of a two-channel 10-bit converter. It is built as synthesizable logic so that it can stand in for the converter when a host-side serial controller is being tested. The host drives an active-low chip select and a serial clock. When chip select falls, the block captures the sample word, the channel bit and the two sub-bits presented at its inputs. Each later falling edge of the serial clock moves the next bit of a fixed 16-bit frame onto the data output. The frame is three 1 bits, then the channel bit, then the sample from its most significant bit down, then the two sub-bits. The host reads each bit on the following rising edge.

If the host keeps clocking after the last sub-bit, the output carries 0s for as long as chip select stays low. Raising chip select at any point ends the frame and returns the output to idle. A frame that is cut short this way is abandoned, and the next chip-select fall starts again from the header. Chip select and serial clock are treated as asynchronous pins. Both are brought into the system clock domain through synchronizer chains, and their edges are detected there. The output therefore follows a serial-clock fall after a short fixed number of system clocks, which requires the system clock to run several times faster than the serial clock.

Top module: `adc_frame_tx`

## Requirements
- R1: While chip select is high, `sdo_o` is 0 and `sdo_oe_o` is 0.
- R2: After chip select falls, `sdo_oe_o` is 1 and `sdo_o` is 0 until the first serial-clock fall.
- R3: The first three serial-clock falls after chip select falls each put a 1 on `sdo_o`.
- R4: The fourth fall puts the captured channel bit on `sdo_o`.
- R5: Falls five to fourteen put the captured sample on `sdo_o`, from bit 9 down to bit 0.
- R6: Falls fifteen and sixteen put captured sub-bit 1 and then sub-bit 0 on `sdo_o`.
- R7: Every fall after the sixteenth, while chip select stays low, puts 0 on `sdo_o`.
- R8: `sdo_o` changes only after a serial-clock fall, or after a chip-select edge; a rising serial-clock edge leaves it unchanged.
- R9: The sample, channel and sub-bit inputs are captured at the chip-select fall. Changing them during a frame has no effect on that frame.
- R10: Raising chip select partway through a frame aborts it. The next frame starts again from the header and carries the newly captured data.
- R11: Serial-clock edges while chip select is high have no effect. The output stays idle, and the next frame still begins with its header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select from the host (asynchronous) |
| sclk_i | input | 1 | Serial clock from the host (asynchronous, idles low) |
| sample_i | input | DATA_W | Conversion result to send |
| chan_i | input | 1 | Channel identifier bit |
| sub_i | input | 2 | Sub-bits; bit 1 is sent before bit 0 |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable; high while a frame is selected |

## Verification
A wrong bit counter shows up at the ports as a header that is too short or too long, or as padding 0s that start early or late. In every case the error is visible on the first fall where the count diverges, and every later bit of the frame moves with it. A capture register that fails to hold its value, or that reloads mid-frame, corrupts the data bits within one serial-clock period of the input change. This is why inputs are altered while a frame is in flight. Leftover state after an abort, or after clocks that arrive while chip select is high, shows up in the first header bit of the next frame.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  // Frame composition (sample width comes from the top parameter)
  localparam int unsigned HDR_BITS  = 3;
  localparam int unsigned CHAN_BITS = 1;
  localparam int unsigned SUB_BITS  = 2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // deselected
    PH_ARMED = 2'd1,  // selected, no serial-clock fall yet
    PH_SHIFT = 2'd2,  // frame bits going out
    PH_PAD   = 2'd3   // frame done, zeros going out
  } phase_e;

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_lvl_i,
  input  logic             cs_fall_i,
  input  logic             sck_fall_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             clear_o,
  output logic             oe_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output phase_e           phase_o
);

  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_W);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    clear_o = 1'b0;
    if (cs_n_lvl_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      clear_o = 1'b1;
    end else if (cs_fall_i) begin
      phase_d = PH_ARMED;
      cnt_d   = '0;
      load_o  = 1'b1;
    end else if (sck_fall_i && (phase_q != PH_IDLE)) begin
      shift_o = 1'b1;
      if (cnt_q != CNT_END) begin
        cnt_d = cnt_q + 1'b1;
      end
      phase_d = (cnt_d == CNT_END) ? PH_PAD : PH_SHIFT;
    end
    upd_en = clear_o | load_o | shift_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign oe_o      = (phase_q != PH_IDLE);
  assign bit_cnt_o = cnt_q;
  assign phase_o   = phase_q;

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
  import adc_frame_pkg::*;
#(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned FRAME_W = HDR_BITS + CHAN_BITS + DATA_W + SUB_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic                clear_i,
  input  logic [DATA_W-1:0]   sample_i,
  input  logic                chan_i,
  input  logic [SUB_BITS-1:0] sub_i,
  output logic                sdo_o
);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               sdo_q, sdo_d;
  logic               upd_en;

  always_comb begin
    frame_d = frame_q;
    sdo_d   = sdo_q;
    if (clear_i) begin
      frame_d = '0;
      sdo_d   = 1'b0;
    end else if (load_i) begin
      frame_d = {{HDR_BITS{1'b1}}, chan_i, sample_i, sub_i};
      sdo_d   = 1'b0;
    end else if (shift_i) begin
      sdo_d   = frame_q[FRAME_W-1];
      frame_d = {frame_q[FRAME_W-2:0], 1'b0};
    end
    upd_en = clear_i | load_i | shift_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      sdo_q   <= 1'b0;
    end else if (upd_en) begin
      frame_q <= frame_d;
      sdo_q   <= sdo_d;
    end
  end

  assign sdo_o = sdo_q;

endmodule

// File: rtl/adc_frame_tx.sv
module adc_frame_tx
  import adc_frame_pkg::*;
#(
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_i,
  input  logic                sclk_i,
  input  logic [DATA_W-1:0]   sample_i,
  input  logic                chan_i,
  input  logic [SUB_BITS-1:0] sub_i,
  output logic                sdo_o,
  output logic                sdo_oe_o
);

  localparam int unsigned FRAME_W = HDR_BITS + CHAN_BITS + DATA_W + SUB_BITS;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic             cs_n_s, cs_rise, cs_fall;
  logic             sck_s, sck_rise, sck_fall;
  logic             load, shift, clear;
  logic [CNT_W-1:0] bit_cnt;
  phase_e           phase;

  adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cs_n_i),
    .level_o(cs_n_s), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(sclk_i),
    .level_o(sck_s), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  adc_frame_ctrl #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_n_lvl_i(cs_n_s), .cs_fall_i(cs_fall), .sck_fall_i(sck_fall),
    .load_o(load), .shift_o(shift), .clear_o(clear), .oe_o(sdo_oe_o),
    .bit_cnt_o(bit_cnt), .phase_o(phase)
  );

  adc_frame_shift #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .shift_i(shift), .clear_i(clear),
    .sample_i(sample_i), .chan_i(chan_i), .sub_i(sub_i),
    .sdo_o(sdo_o)
  );

endmodule

// File: rtl/adc_frame_chk.sv
module adc_frame_chk #(
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned HDR_BITS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_s,
  input logic             cs_fall,
  input logic             sck_fall,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sdo_o,
  input logic             sdo_oe_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (!sdo_oe_o && !sdo_o)); // R1

  AST_SELECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_oe_o && !sdo_o)); // R2

  AST_HEADER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !cs_n_s && !cs_fall && sdo_oe_o && (bit_cnt < CNT_W'(HDR_BITS))) |=> sdo_o); // R3

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !cs_n_s && !cs_fall && (bit_cnt == CNT_W'(FRAME_W))) |=> !sdo_o); // R7

  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_fall && !cs_n_s) |=> $stable(sdo_o)); // R8

  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (bit_cnt == '0)); // R11

endmodule

bind adc_frame_tx adc_frame_chk #(
  .FRAME_W(FRAME_W), .CNT_W(CNT_W), .HDR_BITS(adc_frame_pkg::HDR_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .cs_fall(cs_fall),
  .sck_fall(sck_fall), .bit_cnt(bit_cnt), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/sim_adc_frame_tx.sv
`timescale 1ns/1ps
module sim_adc_frame_tx;

  localparam int DATA_W = 10;
  localparam int HALF   = 8;   // system clocks per serial-clock half period

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_n, sclk, chan;
  logic [DATA_W-1:0] sample;
  logic [1:0]        sub;
  wire               sdo, sdo_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  adc_frame_tx #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
    .sample_i(sample), .chan_i(chan), .sub_i(sub),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(posedge clk);
    @(negedge clk);
  endtask

  // Expected bit for fall index k (1-based), sent MSB first
  function automatic logic exp_bit(input int k, input logic [DATA_W-1:0] s,
                                   input logic c, input logic [1:0] sb);
    logic [15:0] f;
    f = {3'b111, c, s, sb};
    if (k > 16) return 1'b0;
    return f[16 - k];
  endfunction

  function automatic string req_of(input int k);
    if (k <= 3)  return "R3";
    if (k == 4)  return "R4";
    if (k <= 14) return "R5";
    if (k <= 16) return "R6";
    return "R7";
  endfunction

  // One serial-clock pulse; checks the bit after the fall and after the next rise
  task automatic clk_pulse(input int k, input logic [DATA_W-1:0] s,
                           input logic c, input logic [1:0] sb);
    sclk = 1'b1; wait_half();
    if (k > 1) chk("R8", sdo, exp_bit(k - 1, s, c, sb));
    sclk = 1'b0; wait_half();
    chk(req_of(k), sdo, exp_bit(k, s, c, sb));
  endtask

  task automatic t_reset();
    cs_n = 1'b1; sclk = 1'b0; chan = 1'b0; sample = '0; sub = '0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    wait_half();
    chk("R1", sdo, 0);
    chk("R1", sdo_oe, 0);
  endtask

  task automatic t_frame(input logic [DATA_W-1:0] s, input logic c,
                         input logic [1:0] sb, input int extra);
    sample = s; chan = c; sub = sb;
    cs_n = 1'b0; wait_half();
    chk("R2", sdo_oe, 1);
    chk("R2", sdo, 0);
    for (int k = 1; k <= 16 + extra; k++) clk_pulse(k, s, c, sb);
    cs_n = 1'b1; wait_half();
    chk("R1", sdo, 0);
    chk("R1", sdo_oe, 0);
  endtask

  task automatic t_latch();
    logic [DATA_W-1:0] s0 = 10'h2C5;
    sample = s0; chan = 1'b1; sub = 2'b01;
    cs_n = 1'b0; wait_half();
    for (int k = 1; k <= 16; k++) begin
      if (k == 2) begin sample = ~s0; chan = 1'b0; sub = 2'b10; end
      clk_pulse(k, s0, 1'b1, 2'b01);
      if (k == 8) chk("R9", sdo, exp_bit(8, s0, 1'b1, 2'b01));
    end
    cs_n = 1'b1; wait_half();
  endtask

  task automatic t_abort();
    sample = 10'h155; chan = 1'b0; sub = 2'b11;
    cs_n = 1'b0; wait_half();
    for (int k = 1; k <= 7; k++) clk_pulse(k, 10'h155, 1'b0, 2'b11);
    cs_n = 1'b1; wait_half();
    chk("R10", sdo_oe, 0);
    chk("R10", sdo, 0);
    sample = 10'h0F0; chan = 1'b1; sub = 2'b00;
    cs_n = 1'b0; wait_half();
    for (int k = 1; k <= 16; k++) begin
      clk_pulse(k, 10'h0F0, 1'b1, 2'b00);
      if (k == 1) chk("R10", sdo, 1);
    end
    cs_n = 1'b1; wait_half();
  endtask

  task automatic t_clocks_deselected();
    cs_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; wait_half();
      sclk = 1'b0; wait_half();
      chk("R11", sdo, 0);
      chk("R11", sdo_oe, 0);
    end
    t_frame(10'h001, 1'b0, 2'b10, 0);
  endtask

  initial begin
    t_reset();
    t_frame(10'h3A6, 1'b1, 2'b10, 0);
    t_frame(10'h000, 1'b0, 2'b00, 5);
    t_frame(10'h3FF, 1'b1, 2'b11, 3);
    t_latch();
    t_abort();
    t_clocks_deselected();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule